// File: doc/BRIEF.md
# MMU Control and Exception Register Bank

This block holds the software-visible state that steers a memory management unit and records exception information. It has nine 32-bit registers: a translation control word, the high and low halves of a page-table entry (the high half carries the address-space identifier in its low 8 bits), a page-table-entry assist word, a translation-table base, a fault address, and three exception code words (trap, general exception, interrupt event). Each register keeps only the bits it defines. Bits it does not keep read back as zero.

Two writes have side effects that go to the translation hardware outside this block. Setting the invalidate bit in the control word raises a one-cycle invalidate-all pulse. The invalidate bit itself is never stored. Writing a page-table-entry high word raises a one-cycle flush pulse only when the new address-space identifier differs from the stored one. The translation buffer and the translation logic sit elsewhere and only consume these pulses and the register contents.

Access uses a simple word-addressed port. A write takes effect at the clock edge that samples it. Read data appears one cycle after the read request. An address outside the map reads as zero and raises a one-cycle error flag.

Top module: `mmu_reg_bank`

## Requirements
- R1: After reset every register reads 0, and `tlbInvalidate`, `tlbFlush` and `accErr` are low.
- R2: A write to address 0 (control) with wdata bit 2 (invalidate) set raises `tlbInvalidate` for exactly the cycle after the write. A write to address 0 with bit 2 clear leaves it low.
- R3: The control register at address 0 stores every bit except bit 2. Reads of address 0 always return bit 2 as 0.
- R4: A write to address 1 (page-table-entry high) stores all 32 bits. `tlbFlush` is high in the cycle after that write only if wdata bits 7:0 differ from the stored bits 7:0.
- R5: Address 3 (assist) keeps wdata bits 3:0. Bits 31:4 read as 0.
- R6: Addresses 6, 7 and 8 (trap code, exception code, interrupt code) keep wdata bits 10:0. Bits 31:11 read as 0.
- R7: Addresses 2 (page-table-entry low), 4 (table base) and 5 (fault address) store and return all 32 bits.
- R8: `rdata` carries the register addressed by a read in the cycle after `rdEn`. It holds its value until the next read. A read issued together with a write to the same address returns the value from before the write.
- R9: A read or write to an address of 9 or above raises `accErr` for one cycle after the access. Such a read returns 0, and such a write changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write request |
| rdEn | input | 1 | Read request |
| addr | input | ADDR_W (4) | Word address of the register |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, one cycle after `rdEn` |
| tlbInvalidate | output | 1 | One-cycle invalidate-all pulse |
| tlbFlush | output | 1 | One-cycle flush pulse on identifier change |
| accErr | output | 1 | One-cycle flag for an access outside the map |

## Verification
Faults in this block appear at the ports quickly. A wrong keep mask or a lost write shows as a wrong value on `rdata` one cycle after the next read of that register. A stale identifier copy shows in the cycle after the next page-table-entry high write, as a flush pulse that is missing or spurious. A stored invalidate bit would appear at bit 2 of the next control read. A bad decode either raises `accErr` on a valid address or changes a neighbouring register, which the next read of that register exposes.

// File: rtl/mmu_reg_pkg.sv
package mmu_reg_pkg;

  localparam int NUM_REGS = 9;
  localparam int IDX_W    = $clog2(NUM_REGS);

  localparam int IX_CTRL   = 0;
  localparam int IX_PTEHI  = 1;
  localparam int IX_PTELO  = 2;
  localparam int IX_PTEAST = 3;
  localparam int IX_TBASE  = 4;
  localparam int IX_FAULT  = 5;
  localparam int IX_TRAP   = 6;
  localparam int IX_EXCEVT = 7;
  localparam int IX_INTEVT = 8;

  typedef struct packed {
    logic [NUM_REGS-1:0] wrSel;
    logic                rdEn;
    logic                rdHit;
    logic [IDX_W-1:0]    rdIdx;
  } strobe_t;

endpackage

// File: rtl/mmu_reg_ctrl.sv
module mmu_reg_ctrl
  import mmu_reg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strb,
  output logic              accErr
);

  logic hit;
  assign hit = (addr < ADDR_W'(NUM_REGS));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_wrSel
    assign strb.wrSel[i] = wrEn && (addr == ADDR_W'(i));
  end

  assign strb.rdEn  = rdEn;
  assign strb.rdHit = hit;
  assign strb.rdIdx = IDX_W'(addr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) accErr <= 1'b0;
    else       accErr <= (wrEn || rdEn) && !hit;
  end

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> ($past(addr) >= ADDR_W'(NUM_REGS)));

  // R9
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.wrSel));

endmodule

// File: rtl/mmu_reg_dp.sv
module mmu_reg_dp
  import mmu_reg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ASID_W   = 8,
  parameter int CODE_W   = 11,
  parameter int ASSIST_W = 4,
  parameter int TI_BIT   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              tlbInvalidate,
  output logic              tlbFlush
);

  localparam logic [DATA_W-1:0] CODE_KEEP   = {{(DATA_W-CODE_W){1'b0}}, {CODE_W{1'b1}}};
  localparam logic [DATA_W-1:0] ASSIST_KEEP = {{(DATA_W-ASSIST_W){1'b0}}, {ASSIST_W{1'b1}}};
  localparam logic [DATA_W-1:0] CTRL_KEEP   = ~(DATA_W'(1) << TI_BIT);

  function automatic logic [DATA_W-1:0] keepOf(int idx);
    case (idx)
      IX_CTRL:                       keepOf = CTRL_KEEP;
      IX_PTEAST:                     keepOf = ASSIST_KEEP;
      IX_TRAP, IX_EXCEVT, IX_INTEVT: keepOf = CODE_KEEP;
      default:                       keepOf = '1;
    endcase
  endfunction

  logic [DATA_W-1:0] regQ [NUM_REGS];
  logic [DATA_W-1:0] rdataQ;
  logic              invQ;
  logic              flushQ;
  logic              asidChange;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [DATA_W-1:0] KEEP = keepOf(i);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               regQ[i] <= '0;
      else if (strb.wrSel[i])  regQ[i] <= wdata & KEEP;
    end
  end

  assign asidChange = (wdata[ASID_W-1:0] != regQ[IX_PTEHI][ASID_W-1:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      invQ   <= 1'b0;
      flushQ <= 1'b0;
    end else begin
      invQ   <= strb.wrSel[IX_CTRL] && wdata[TI_BIT];
      flushQ <= strb.wrSel[IX_PTEHI] && asidChange;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdataQ <= '0;
    else if (strb.rdEn) rdataQ <= strb.rdHit ? regQ[strb.rdIdx] : '0;
  end

  assign rdata         = rdataQ;
  assign tlbInvalidate = invQ;
  assign tlbFlush      = flushQ;

  // R2
  inv_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    tlbInvalidate |-> $past(strb.wrSel[IX_CTRL] && wdata[TI_BIT]));

  // R3
  ti_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.rdHit && strb.rdIdx == IDX_W'(IX_CTRL)) |=> !rdataQ[TI_BIT]);

  // R4
  flush_same_asid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrSel[IX_PTEHI] && wdata[ASID_W-1:0] == regQ[IX_PTEHI][ASID_W-1:0]) |=> !tlbFlush);

  // R4
  ptehi_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSel[IX_PTEHI] |=> (regQ[IX_PTEHI] == $past(wdata)));

  // R5
  assist_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.rdHit && strb.rdIdx == IDX_W'(IX_PTEAST))
      |=> (rdataQ[DATA_W-1:ASSIST_W] == '0));

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> $stable(rdataQ));

  // R9
  miss_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && !strb.rdHit) |=> (rdataQ == '0));

endmodule

// File: rtl/mmu_reg_bank.sv
module mmu_reg_bank
  import mmu_reg_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int ASID_W   = 8,
  parameter int CODE_W   = 11,
  parameter int ASSIST_W = 4,
  parameter int TI_BIT   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              tlbInvalidate,
  output logic              tlbFlush,
  output logic              accErr
);

  strobe_t strb;

  mmu_reg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .strb   (strb),
    .accErr (accErr)
  );

  mmu_reg_dp #(
    .DATA_W   (DATA_W),
    .ASID_W   (ASID_W),
    .CODE_W   (CODE_W),
    .ASSIST_W (ASSIST_W),
    .TI_BIT   (TI_BIT)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .wdata         (wdata),
    .rdata         (rdata),
    .tlbInvalidate (tlbInvalidate),
    .tlbFlush      (tlbFlush)
  );

endmodule

// File: tb/mmu_reg_bank_tb.sv
module mmu_reg_bank_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn, rdEn;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        tlbInvalidate, tlbFlush, accErr;

  int nChecks = 0;
  int nFail   = 0;

  always #10 clk = ~clk;

  mmu_reg_bank u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tlbInvalidate(tlbInvalidate),
    .tlbFlush(tlbFlush), .accErr(accErr)
  );

  typedef struct packed {
    logic [3:0]  a;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 32'hDEADBEEF, 32'hDEADBEEF},  // R7
    '{4'd4, 32'h12345678, 32'h12345678},  // R7
    '{4'd5, 32'hFFFFFFFF, 32'hFFFFFFFF},  // R7
    '{4'd3, 32'hFFFFFFFF, 32'h0000000F},  // R5
    '{4'd3, 32'hA5A5A5A6, 32'h00000006},  // R5
    '{4'd6, 32'hFFFFFFFF, 32'h000007FF},  // R6
    '{4'd7, 32'h0000F123, 32'h00000123},  // R6
    '{4'd8, 32'hABCDE5A5, 32'h000005A5},  // R6
    '{4'd0, 32'hFFFFFFFF, 32'hFFFFFFFB},  // R3
    '{4'd0, 32'h00000104, 32'h00000100},  // R3
    '{4'd1, 32'h12345678, 32'h12345678}   // R4
  };

  function automatic string reqOf(logic [3:0] a);
    case (a)
      4'd0:             reqOf = "R3";
      4'd1:             reqOf = "R4";
      4'd3:             reqOf = "R5";
      4'd6, 4'd7, 4'd8: reqOf = "R6";
      default:          reqOf = "R7";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdata;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: outputs quiet and every register zero after reset
    chk("R1 pulses", {29'd0, tlbInvalidate, tlbFlush, accErr}, 32'd0);
    for (int i = 0; i < 9; i++) begin
      doRead(4'(i), rd);
      chk("R1 reg", rd, 32'd0);
      chk("R1 err", {31'd0, accErr}, 32'd0);
    end

    // Table walk: write, then read back the masked value
    for (int i = 0; i < NV; i++) begin
      doWrite(VECS[i].a, VECS[i].d);
      doRead(VECS[i].a, rd);
      chk(reqOf(VECS[i].a), rd, VECS[i].e);
    end

    // R2: invalidate pulse lasts exactly one cycle
    doWrite(4'd0, 32'h00000004);
    chk("R2 pulse", {31'd0, tlbInvalidate}, 32'd1);
    @(negedge clk);
    chk("R2 width", {31'd0, tlbInvalidate}, 32'd0);
    doWrite(4'd0, 32'h00000010);
    chk("R2 no-ti", {31'd0, tlbInvalidate}, 32'd0);
    doRead(4'd0, rd);
    chk("R3 ti-clear", rd, 32'h00000010);

    // R4: same identifier gives no flush, but the word is stored
    doWrite(4'd1, 32'hAAAA5578);
    chk("R4 same-asid", {31'd0, tlbFlush}, 32'd0);
    doRead(4'd1, rd);
    chk("R4 stored", rd, 32'hAAAA5578);
    doWrite(4'd1, 32'hAAAA5579);
    chk("R4 flush", {31'd0, tlbFlush}, 32'd1);
    @(negedge clk);
    chk("R4 width", {31'd0, tlbFlush}, 32'd0);

    // R9: unmapped write raises error and changes nothing
    doWrite(4'd12, 32'h55555555);
    chk("R9 wr-err", {31'd0, accErr}, 32'd1);
    @(negedge clk);
    chk("R9 err-width", {31'd0, accErr}, 32'd0);
    doRead(4'd2, rd);
    chk("R9 untouched", rd, 32'hDEADBEEF);
    doRead(4'd15, rd);
    chk("R9 rd-zero", rd, 32'd0);
    chk("R9 rd-err", {31'd0, accErr}, 32'd1);

    // R8: read and write together return the old value, then hold
    @(negedge clk);
    wrEn = 1'b1; rdEn = 1'b1; addr = 4'd2; wdata = 32'h11111111;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    chk("R8 old-value", rdata, 32'hDEADBEEF);
    doWrite(4'd4, 32'h0BADF00D);
    repeat (3) @(negedge clk);
    chk("R8 hold", rdata, 32'hDEADBEEF);
    doRead(4'd2, rd);
    chk("R8 new-value", rd, 32'h11111111);

    summary();
    $finish;
  end

endmodule